// File: doc/BRIEF.md
# Reset Cause Sequencer

This block collects the four reasons a device can enter reset: power-on, a low level on the shared reset pin, a watchdog (COP) timeout and a clock-monitor failure. When one of them occurs, it pulls the open-drain reset pin low for a fixed number of E-clock ticks and then lets go. A fixed number of ticks later it samples the pin again. A pin that is still low means something outside the chip holds it, so the reset is classed as external and the normal vector is chosen. A pin that has returned high means the cause was internal, and the vector of that cause is kept.

The core sees one reset-active level and a 2-bit vector-select code. Power-on drives the block asynchronously, so reset is entered with no clock running. Leaving reset needs both the system clock and E-clock ticks. The states are `S_IDLE` (no reset), `S_PULL` (pin driven low), `S_WAIT` (pin released, waiting to sample) and `S_HOLD` (classified, waiting for a tick with the pin high). The transitions are:

- idle-to-pull: a request is seen, or power-on forces the state asynchronously.
- pull-to-wait: the last pull tick.
- wait-to-hold: the sampling tick, where the vector is classified.
- hold-to-idle: an E-clock tick with the synchronized pin high.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_in` is high, `core_rst` and `rst_pin_pull` are 1 and `vec_sel` is 2'b00. This holds with no clock edge.
- R2: After `por_in` falls, the block runs the full pull and sample sequence and ends with `vec_sel` = 2'b00.
- R3: After reset entry, `rst_pin_pull` is high until the `PULL_CYC`-th (16) E-clock tick has been taken, and then drops.
- R4: The pin is sampled on the `SAMPLE_CYC`-th (8) E-clock tick after release. If the synchronized pin is low there, `vec_sel` becomes 2'b00 (normal).
- R5: If the pin is high at the sample, the internal cause is kept. COP gives 2'b10 and clock monitor gives 2'b01.
- R6: Clock monitor wins over COP when both pulse in the same cycle. Power-on during a running sequence restarts it with the normal vector.
- R7: From idle, a low on `rst_pin_in` starts a sequence. `rst_pin_pull` rises on the third clock edge after the pin falls: two synchronizer flops, then the state register.
- R8: `core_rst` stays high from entry until classification. It drops on the first E-clock tick after classification at which the synchronized pin is high. An external low held past classification keeps reset active.
- R9: COP and clock-monitor pulses that arrive during an active sequence are ignored. The pull length and the final vector do not change.
- R10: `vec_sel` holds its code after reset ends. It is never 2'b11.
- R11: With no cause present, `core_rst` and `rst_pin_pull` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_in | input | 1 | Power-on pulse, active high, asynchronous |
| cop_fail | input | 1 | Watchdog timeout pulse, synchronous to clk |
| cm_fail | input | 1 | Clock-monitor failure pulse, synchronous to clk |
| rst_pin_in | input | 1 | Raw level read back from the reset pin |
| eclk_en | input | 1 | One-cycle E-clock tick enable |
| rst_pin_pull | output | 1 | 1 = drive the reset pin low |
| core_rst | output | 1 | Reset active towards the core |
| vec_sel | output | 2 | 00 normal, 01 clock monitor, 10 COP |

## Verification
Each result has a known due time:

| Result | When it is due |
|---|---|
| Power-on entry | Checked one nanosecond after `por_in` rises, before any edge |
| Internal causes | Pulling on the first clock edge after the pulse |
| External pin | Pulling on the third edge after the pin falls |
| End of pulling | After the 16th E-clock tick |
| Classification | After the 8th tick that follows release |
| Release of `core_rst` | On the first later tick with the pin high, counted as at least three edges after the external source lets go |

The bench steps on falling clock edges. At each step it records whether the rising edge just passed carried a tick, and compares every output against a tick count it keeps itself. The E-clock divider is swept over ratios of 1, 2 and 3.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PULL = 2'd1,
        S_WAIT = 2'd2,
        S_HOLD = 2'd3
    } rsq_state_t;

    typedef enum logic [1:0] {
        CAUSE_NORM = 2'b00,
        CAUSE_CM   = 2'b01,
        CAUSE_COP  = 2'b10
    } rsq_cause_t;

endpackage

// File: rtl/rsq_pin_sync.sv
module rsq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    // The chain clears to 0 because the pin is pulled low during power-on.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain_q <= '0;
                else      chain_q <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain_q <= '0;
                else      chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_cause_arb.sv
module rsq_cause_arb
    import rsq_pkg::*;
(
    input  logic       cm_fail,
    input  logic       cop_fail,
    input  logic       pin_low,
    output logic       req,
    output rsq_cause_t req_cause
);
    // Priority: clock monitor first, then COP, then the external pin.
    always_comb begin
        req       = 1'b1;
        req_cause = CAUSE_NORM;
        if (cm_fail)       req_cause = CAUSE_CM;
        else if (cop_fail) req_cause = CAUSE_COP;
        else if (pin_low)  req_cause = CAUSE_NORM;
        else               req = 1'b0;
    end
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int PULL_CYC   = 16,
    parameter int SAMPLE_CYC = 8
) (
    input  logic       clk,
    input  logic       por,
    input  logic       eclk_en,
    input  logic       pin_s,
    input  logic       req,
    input  rsq_cause_t req_cause,
    output logic       pin_pull,
    output logic       core_rst,
    output logic [1:0] vec_sel
);
    localparam int CNT_MAX = (PULL_CYC > SAMPLE_CYC) ? PULL_CYC : SAMPLE_CYC;
    localparam int CW      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CW-1:0] PULL_LAST = CW'(PULL_CYC - 1);
    localparam logic [CW-1:0] SAMP_LAST = CW'(SAMPLE_CYC - 1);

    rsq_state_t    st, st_nx;
    rsq_cause_t    cause, cause_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // State register: power-on enters reset without a clock.
    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            st    <= S_PULL;
            cnt   <= '0;
            cause <= CAUSE_NORM;
        end else begin
            st    <= st_nx;
            cnt   <= cnt_nx;
            cause <= cause_nx;
        end
    end

    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        cause_nx = cause;
        unique case (st)
            S_IDLE: begin
                if (req) begin
                    st_nx    = S_PULL;
                    cnt_nx   = '0;
                    cause_nx = req_cause;
                end
            end
            S_PULL: begin
                if (eclk_en) begin
                    if (cnt == PULL_LAST) begin
                        st_nx  = S_WAIT;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            S_WAIT: begin
                if (eclk_en) begin
                    if (cnt == SAMP_LAST) begin
                        st_nx = S_HOLD;
                        if (!pin_s) cause_nx = CAUSE_NORM;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            S_HOLD: begin
                if (eclk_en && pin_s) st_nx = S_IDLE;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        pin_pull = (st == S_PULL);
        core_rst = (st != S_IDLE);
        vec_sel  = cause;
    end

    a_r3_pull_inside_reset: assert property (@(posedge clk) disable iff (por)
        pin_pull |-> core_rst);

    a_r3_pull_ends_on_tick: assert property (@(posedge clk) disable iff (por)
        $fell(pin_pull) |-> $past(eclk_en));

    a_r8_release_on_tick_pin_high: assert property (@(posedge clk) disable iff (por)
        $fell(core_rst) |-> ($past(eclk_en) && $past(pin_s)));

    a_r9_cause_frozen_while_pulling: assert property (@(posedge clk) disable iff (por)
        (st == S_PULL) |=> $stable(vec_sel));

    a_r4_reclass_only_to_normal: assert property (@(posedge clk) disable iff (por)
        (core_rst && $past(core_rst) && !$stable(vec_sel)) |-> (vec_sel == 2'b00));

    a_r10_code_legal: assert property (@(posedge clk) disable iff (por)
        vec_sel != 2'b11);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rsq_pkg::*;
#(
    parameter int PULL_CYC    = 16,
    parameter int SAMPLE_CYC  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_in,
    input  logic       cop_fail,
    input  logic       cm_fail,
    input  logic       rst_pin_in,
    input  logic       eclk_en,
    output logic       rst_pin_pull,
    output logic       core_rst,
    output logic [1:0] vec_sel
);
    logic       pin_s;
    logic       req;
    rsq_cause_t req_cause;

    rsq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .arst  (por_in),
        .d_in  (rst_pin_in),
        .q_out (pin_s)
    );

    rsq_cause_arb u_arb (
        .cm_fail   (cm_fail),
        .cop_fail  (cop_fail),
        .pin_low   (!pin_s),
        .req       (req),
        .req_cause (req_cause)
    );

    rsq_fsm #(.PULL_CYC(PULL_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_fsm (
        .clk       (clk),
        .por       (por_in),
        .eclk_en   (eclk_en),
        .pin_s     (pin_s),
        .req       (req),
        .req_cause (req_cause),
        .pin_pull  (rst_pin_pull),
        .core_rst  (core_rst),
        .vec_sel   (vec_sel)
    );
endmodule

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;
    localparam int PULL = 16;
    localparam int SAMP = 8;

    logic       clk = 1'b0;
    logic       por_in = 1'b0;
    logic       cop_fail = 1'b0;
    logic       cm_fail = 1'b0;
    logic       eclk_en = 1'b1;
    logic       ext_low = 1'b0;
    logic       rst_pin_pull, core_rst;
    logic [1:0] vec_sel;
    wire        rst_pin_in = !(rst_pin_pull || ext_low);

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int div = 1;
    logic en_used = 1'b0;

    always #4 clk = ~clk;

    reset_sequencer #(.PULL_CYC(PULL), .SAMPLE_CYC(SAMP), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .por_in(por_in), .cop_fail(cop_fail), .cm_fail(cm_fail),
        .rst_pin_in(rst_pin_in), .eclk_en(eclk_en),
        .rst_pin_pull(rst_pin_pull), .core_rst(core_rst), .vec_sel(vec_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // One falling edge: record the tick the last rising edge used, then set the next one.
    task automatic step();
        @(negedge clk);
        en_used  = eclk_en;
        cop_fail = 1'b0;
        cm_fail  = 1'b0;
        cyc++;
        eclk_en  = ((cyc % div) == 0);
    endtask

    task automatic follow(input int entry, input logic [1:0] ev, input bit hold,
                          input logic [1:0] inj, input string tag);
        int  ticks;
        int  n;
        int  guard;
        bit  ok;
        bit  dropped;
        if (entry > 0) begin
            ok = 1'b1;
            for (int i = 1; i < entry; i++) begin
                step();
                if (rst_pin_pull !== 1'b0) ok = 1'b0;
            end
            step();
            if (rst_pin_pull !== 1'b1 || core_rst !== 1'b1) ok = 1'b0;
            chk(ok, {tag, " entry latency"}, rst_pin_pull, 1);
        end
        ticks = 0; ok = 1'b1; guard = 0;
        while (ticks < PULL && guard < 200) begin
            if (ticks == 3 && inj != 2'b00) begin
                cop_fail = inj[0];
                cm_fail  = inj[1];
            end
            step();
            guard++;
            ticks += int'(en_used);
            if (rst_pin_pull !== (ticks < PULL)) ok = 1'b0;
            if (core_rst !== 1'b1) ok = 1'b0;
        end
        chk(ok && guard < 200, {tag, " R3 pull length"}, ticks, PULL);
        ticks = 0; ok = 1'b1; guard = 0;
        while (ticks < SAMP && guard < 200) begin
            step();
            guard++;
            ticks += int'(en_used);
            if (core_rst !== 1'b1 || rst_pin_pull !== 1'b0) ok = 1'b0;
        end
        chk(ok && core_rst === 1'b1, {tag, " R8 reset held until classified"}, core_rst, 1);
        chk(vec_sel === ev, {tag, " R4/R5 classified vector"}, vec_sel, ev);
        n = hold ? 0 : 100;
        if (hold) ext_low = 1'b0;
        ok = 1'b1; dropped = 1'b0; guard = 0;
        while (!dropped && guard < 100) begin
            step();
            guard++;
            n++;
            dropped = en_used && (n >= 3);
            if (core_rst !== !dropped) ok = 1'b0;
        end
        chk(ok && dropped, {tag, " R8 release timing"}, core_rst, 0);
        chk(vec_sel === ev, {tag, " R10 vector held after release"}, vec_sel, ev);
        repeat (3) step();
    endtask

    task automatic por_pulse(input string tag);
        #2 por_in = 1'b1;
        #1;
        chk(core_rst === 1'b1 && rst_pin_pull === 1'b1 && vec_sel === 2'b00,
            {tag, " R1 asynchronous entry"}, {core_rst, rst_pin_pull, vec_sel}, 4'b1100);
        @(negedge clk);
        por_in = 1'b0;
        follow(0, 2'b00, 1'b0, 2'b00, {tag, " R2"});
    endtask

    initial begin
        #1 por_in = 1'b1;
        #1;
        chk(core_rst === 1'b1 && rst_pin_pull === 1'b1 && vec_sel === 2'b00,
            "R1 reset state at power-on", {core_rst, rst_pin_pull, vec_sel}, 4'b1100);
        repeat (3) @(negedge clk);
        por_in = 1'b0;
        follow(0, 2'b00, 1'b0, 2'b00, "R2 cold start");

        begin
            bit ok = 1'b1;
            for (int i = 0; i < 40; i++) begin
                step();
                if (core_rst !== 1'b0 || rst_pin_pull !== 1'b0) ok = 1'b0;
            end
            chk(ok, "R11 idle stays quiet", core_rst, 0);
        end

        for (int d = 1; d <= 3; d++) begin
            div = d;
            step();
            cop_fail = 1'b1;
            follow(1, 2'b10, 1'b0, 2'b00, "R5 cop");
            cm_fail = 1'b1;
            follow(1, 2'b01, 1'b0, 2'b00, "R5 clock monitor");
            cop_fail = 1'b1; cm_fail = 1'b1;
            follow(1, 2'b01, 1'b0, 2'b00, "R6 cm over cop");
            ext_low = 1'b1;
            follow(3, 2'b00, 1'b1, 2'b00, "R7 external pin");
            ext_low = 1'b1; cop_fail = 1'b1;
            follow(1, 2'b00, 1'b1, 2'b00, "R4 cop overridden by held pin");
            cm_fail = 1'b1;
            follow(1, 2'b01, 1'b0, 2'b01, "R9 cop ignored during cm");
            cop_fail = 1'b1;
            follow(1, 2'b10, 1'b0, 2'b10, "R9 cm ignored during cop");
            cop_fail = 1'b1;
            repeat (5) step();
            por_pulse("R6 power-on restart");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule